// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block is the programmable feedback divider of a frequency synthesizer loop. It is clocked by the output of an external dual-modulus prescaler, which divides by P or by P+1. The block drives that prescaler's modulus-select line. It emits one divided pulse for every P·N + A cycles of the prescaler's input. Two down-counters run together. The main counter spans N prescaler output periods. The swallow counter keeps the prescaler at P+1 for the first A of those periods.

The ratio words come from a holding register outside the block. They are sampled only when the main counter reloads. A new setting therefore starts at a clean cycle boundary. A main ratio below 16 is refused, and so is a swallow ratio larger than the main ratio. In either case the block raises an error flag and stays idle until a legal setting is present at a reload.

Top module: `pulse_swallow_div`

## Requirements
- R1: While reset is held, and right after it, `mod_sel` and `div_pulse` are 0.
- R2: With legal words, consecutive `div_pulse` pulses are exactly `n_word` clocks apart.
- R3: Within each cycle, `mod_sel` is 1 (select P+1) for exactly the first `a_word` clocks and 0 for the rest. `a_word` = 0 keeps it at 0 for the whole cycle.
- R4: For a prescaler ratio P, one cycle spans A·(P+1) + (N−A)·P = P·N + A prescaler input periods.
- R5: `div_pulse` is high for exactly one clock, in the last clock of each cycle.
- R6: If `n_word` < 16, `cfg_err` is 1 in the same cycle. At the next reload the block goes idle, with no pulse and `mod_sel` held at 0.
- R7: If `a_word` > `n_word`, the block raises `cfg_err` and goes idle as in R6.
- R8: A change to the words in the middle of a cycle does not alter that cycle. The new values apply from the next cycle on.
- R9: The edge ratios N = 16 and N = 2047, with A = 0, A = N and A = 127, divide as in R2 and R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Prescaler output, used as the count clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_word | input | 7 | Swallow ratio A, from the holding register |
| n_word | input | 11 | Main ratio N, from the holding register |
| mod_sel | output | 1 | 1 = prescaler divides by P+1, 0 = by P |
| div_pulse | output | 1 | One-clock divided output pulse |
| cfg_err | output | 1 | Illegal ratio words are present |

## Verification
The bench targets the following corner cases.
- **Extreme swallow counts.** It runs A = 0 and A = N. A design that is off by one in the swallow counter would leave `mod_sel` set one clock too long, or hold it high when nothing should be swallowed.
- **Smallest and largest main ratios.** It runs N = 16 and N = 2047. These expose comparator or terminal-count errors that drop or add a clock.
- **Reload boundary.** It rewrites the words in the middle of a cycle. A design that loads them at once would shorten the running cycle.
- **Forbidden words.** It applies N = 15 and A > N, both from idle and while running. A design that ignores the check would go on emitting pulses.

// File: rtl/sw_div_pkg.sv
package sw_div_pkg;
  localparam int unsigned SWALLOW_W = 7;
  localparam int unsigned MAIN_W    = 11;
  localparam int unsigned MAIN_MIN  = 16;
endpackage

// File: rtl/sd_rst_sync.sv
module sd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/sd_cfg_check.sv
module sd_cfg_check #(
  parameter int unsigned A_W   = 7,
  parameter int unsigned N_W   = 11,
  parameter int unsigned N_MIN = 16
) (
  input  logic [A_W-1:0] a_val,
  input  logic [N_W-1:0] n_val,
  output logic           cfg_ok
);
  localparam logic [N_W-1:0] NMIN_V = N_W'(N_MIN);
  logic [N_W-1:0] a_ext;
  logic           n_legal;
  logic           a_legal;

  generate
    if (N_W > A_W) begin : g_ext
      assign a_ext = {{(N_W-A_W){1'b0}}, a_val};
    end else begin : g_trunc
      assign a_ext = a_val[N_W-1:0];
    end
  endgenerate

  always_comb begin
    n_legal = (n_val >= NMIN_V);
    a_legal = (a_ext <= n_val);
    cfg_ok  = n_legal && a_legal;
  end
endmodule

// File: rtl/sd_swallow_cnt.sv
module sd_swallow_cnt #(
  parameter int unsigned A_W = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [A_W-1:0] load_val,
  output logic           active
);
  logic [A_W-1:0] cnt_q;
  logic [A_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)                cnt_d = load_val;
    else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign active = (cnt_q != '0);
endmodule

// File: rtl/sd_prog_cnt.sv
module sd_prog_cnt #(
  parameter int unsigned N_W = 11
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           dec_en,
  input  logic [N_W-1:0] load_val,
  output logic [N_W-1:0] cnt,
  output logic           terminal
);
  localparam logic [N_W-1:0] ONE = N_W'(1);
  logic [N_W-1:0] cnt_q;
  logic [N_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)        cnt_d = load_val;
    else if (dec_en) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt      = cnt_q;
  assign terminal = (cnt_q == ONE);
endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div
  import sw_div_pkg::*;
#(
  parameter int unsigned A_W   = SWALLOW_W,
  parameter int unsigned N_W   = MAIN_W,
  parameter int unsigned N_MIN = MAIN_MIN
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [A_W-1:0] a_word,
  input  logic [N_W-1:0] n_word,
  output logic           mod_sel,
  output logic           div_pulse,
  output logic           cfg_err
);
  logic           rst_i_n;
  logic           cfg_ok;
  logic           run_q;
  logic           run_d;
  logic           reload;
  logic           term;
  logic           swallow_act;
  logic [N_W-1:0] n_cnt;

  sd_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  sd_cfg_check #(.A_W(A_W), .N_W(N_W), .N_MIN(N_MIN)) u_cfg (
    .a_val  (a_word),
    .n_val  (n_word),
    .cfg_ok (cfg_ok)
  );

  // Reload when idle or at terminal count; words are sampled only here.
  always_comb begin
    reload = !run_q || term;
    run_d  = reload ? cfg_ok : run_q;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) run_q <= 1'b0;
    else          run_q <= run_d;
  end

  sd_prog_cnt #(.N_W(N_W)) u_main (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .load     (reload),
    .dec_en   (run_q),
    .load_val (n_word),
    .cnt      (n_cnt),
    .terminal (term)
  );

  sd_swallow_cnt #(.A_W(A_W)) u_swallow (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .load     (reload),
    .load_val (a_word),
    .active   (swallow_act)
  );

  assign mod_sel   = run_q && swallow_act;
  assign div_pulse = run_q && term;
  assign cfg_err   = !cfg_ok;
endmodule

// File: rtl/pulse_swallow_div_chk.sv
module pulse_swallow_div_chk #(
  parameter int unsigned N_W = 11
) (
  input logic           clk,
  input logic           rst_n,
  input logic           run_q,
  input logic [N_W-1:0] n_cnt,
  input logic           mod_sel,
  input logic           div_pulse,
  input logic           cfg_err
);
  assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |=> !div_pulse);

  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (!mod_sel && !div_pulse));

  assert_no_start_on_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && cfg_err) |=> !run_q);

  assert_main_counts_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !div_pulse) |=> (run_q && (n_cnt == $past(n_cnt) - 1'b1)));

  assert_swallow_at_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mod_sel) |-> ($past(div_pulse) || $past(!run_q)));
endmodule

bind pulse_swallow_div pulse_swallow_div_chk #(.N_W(N_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .run_q     (run_q),
  .n_cnt     (n_cnt),
  .mod_sel   (mod_sel),
  .div_pulse (div_pulse),
  .cfg_err   (cfg_err)
);

// File: tb/sim_pulse_swallow_div.sv
module sim_pulse_swallow_div;
  localparam time CLK_PERIOD = 10ns;
  localparam int  PRESC_P    = 8;
  localparam int  WATCHDOG   = 150000;

  typedef struct packed {
    logic [6:0]  a;
    logic [10:0] n;
    logic [11:0] exp_per;
    logic [11:0] exp_hi;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{7'd0,   11'd16,   12'd16,   12'd0},
    '{7'd5,   11'd16,   12'd16,   12'd5},
    '{7'd16,  11'd16,   12'd16,   12'd16},
    '{7'd1,   11'd17,   12'd17,   12'd1},
    '{7'd10,  11'd100,  12'd100,  12'd10},
    '{7'd127, 11'd200,  12'd200,  12'd127},
    '{7'd127, 11'd127,  12'd127,  12'd127},
    '{7'd37,  11'd2047, 12'd2047, 12'd37}
  };

  logic        clk;
  logic        rst_n;
  logic [6:0]  a_word;
  logic [10:0] n_word;
  logic        mod_sel;
  logic        div_pulse;
  logic        cfg_err;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  pulse_swallow_div u0 (
    .clk(clk), .rst_n(rst_n), .a_word(a_word), .n_word(n_word),
    .mod_sel(mod_sel), .div_pulse(div_pulse), .cfg_err(cfg_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  task automatic wait_pulse(output int ok);
    ok = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (div_pulse) begin ok = 1; break; end
    end
  endtask

  // Counts clocks after a pulse up to and including the next pulse.
  // change_at > 0 rewrites the words at that clock of the cycle.
  task automatic measure(output int per, output int hi, output int first_pulse,
                         input int change_at, input logic [6:0] na,
                         input logic [10:0] nn);
    per = 0; hi = 0; first_pulse = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      per++;
      if (mod_sel) hi++;
      if (per == 1) first_pulse = div_pulse;
      if (per == change_at) begin a_word = na; n_word = nn; end
      if (div_pulse) break;
    end
  endtask

  task automatic count_quiet(input int len, output int pulses, output int sels);
    pulses = 0; sels = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (div_pulse) pulses++;
      if (mod_sel) sels++;
    end
  endtask

  initial begin
    wait (cyc >= WATCHDOG);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    finish_run();
  end

  initial begin
    int ok, per, hi, fp, p, s, total;
    rst_n  = 1'b0;
    a_word = 7'd0;
    n_word = 11'd16;
    repeat (3) @(negedge clk);
    check("R1 mod_sel in reset", int'(mod_sel), 0);
    check("R1 div_pulse in reset", int'(div_pulse), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 mod_sel after reset", int'(mod_sel), 0);
    check("R1 div_pulse after reset", int'(div_pulse), 0);

    // Vector table: R2 R3 R4 R5 R9
    foreach (VECS[k]) begin
      a_word = VECS[k].a;
      n_word = VECS[k].n;
      wait_pulse(ok);
      check("R2 pulse seen", ok, 1);
      wait_pulse(ok);
      measure(per, hi, fp, 0, 7'd0, 11'd0);
      check("R2/R9 cycle length", per, int'(VECS[k].exp_per));
      check("R3/R9 swallow clocks", hi, int'(VECS[k].exp_hi));
      check("R5 pulse width", fp, 0);
      total = hi * (PRESC_P + 1) + (per - hi) * PRESC_P;
      check("R4 input periods", total, PRESC_P * int'(VECS[k].n) + int'(VECS[k].a));
      check("R6 no error flag", int'(cfg_err), 0);
    end

    // R8: rewrite mid-cycle
    a_word = 7'd3; n_word = 11'd20;
    wait_pulse(ok); wait_pulse(ok);
    measure(per, hi, fp, 5, 7'd10, 11'd30);
    check("R8 old cycle length", per, 20);
    check("R8 old swallow", hi, 3);
    measure(per, hi, fp, 0, 7'd0, 11'd0);
    check("R8 new cycle length", per, 30);
    check("R8 new swallow", hi, 10);

    // R6: N below 16 from reset
    rst_n = 1'b0;
    a_word = 7'd0; n_word = 11'd15;
    @(negedge clk);
    check("R6 error flag", int'(cfg_err), 1);
    rst_n = 1'b1;
    count_quiet(100, p, s);
    check("R6 no pulse", p, 0);
    check("R6 no swallow", s, 0);

    // R7: A larger than N
    a_word = 7'd40; n_word = 11'd30;
    @(negedge clk);
    check("R7 error flag", int'(cfg_err), 1);
    count_quiet(100, p, s);
    check("R7 no pulse", p, 0);
    check("R7 no swallow", s, 0);

    // R6: bad word while running: current cycle ends, then idle
    a_word = 7'd2; n_word = 11'd40;
    wait_pulse(ok);
    measure(per, hi, fp, 3, 7'd0, 11'd10);
    check("R6 running cycle completes", per, 40);
    count_quiet(120, p, s);
    check("R6 idle after bad reload", p, 0);
    check("R6 swallow idle after bad reload", s, 0);

    // Recovery with legal words
    a_word = 7'd4; n_word = 11'd16;
    wait_pulse(ok);
    measure(per, hi, fp, 0, 7'd0, 11'd0);
    check("R2 recovery length", per, 16);
    check("R3 recovery swallow", hi, 4);

    finish_run();
  end
endmodule